// File: doc/BRIEF.md
# Redundant PCM Line Mismatch Monitor

The monitor watches two pairs of duplicated serial PCM receive lines: line 0 against line 1, and line 2 against line 3. On each rising edge of the bit clock it compares the two lines of every enabled pair. The first disagreement it finds raises a mismatch status bit and drives a level interrupt. It also records a cause word: which pairs disagreed, and the time slot and bit index in the frame where that happened.

Software drives a small register port. A control register holds the two pair enables, the PCM mode field and the interrupt mask. Reading the status register clears the mismatch bit. Reading the cause register re-arms the detector. A two-state interlock machine enforces this handshake. In state `ARMED_ST`, a detected mismatch takes the `capture` transition to `LOCKED_ST`. In state `LOCKED_ST`, every further mismatch is ignored, and a read of the cause register takes the `rearm` transition back to `ARMED_ST`.

Top module: `pcm_redund_cmp`

## Requirements
- R1: After reset, the control register (address 0), the status register (address 1) and the cause register (address 2) all read 0, and `irq` is low. Both pair enables are therefore off after reset.
- R2: With control bit 0 set, a difference between `rxd[0]` and `rxd[1]` at a bit-clock rising edge sets status bit 0. The new value is visible after the first `clk` edge that sees `bclk` high following a low sample.
- R3: With control bit 1 set, a difference between `rxd[2]` and `rxd[3]` sets status bit 0 in the same way.
- R4: A pair whose enable bit is 0 never produces a mismatch, whatever the data on its lines.
- R5: When the mode field (control bits 3:2) equals 2, the comparison of lines 0 and 1 is off, whatever value control bit 0 holds. The pair of lines 2 and 3 still works.
- R6: A read of the status register returns its current value and clears bit 0, unless a new capture happens in the same cycle.
- R7: After a capture, further mismatches neither set the status bit nor change the cause register until the cause register has been read.
- R8: The cause register holds these fields: bit 0 is set when lines 0/1 differed, bit 1 is set when lines 2/3 differed, bits 4:2 hold the bit index, and bits 9:5 hold the time slot of the captured bit. The position is 0 at a bit sampled with `fsync` high, and it increases by one on each later bit.
- R9: `irq` is high exactly when status bit 0 is 1 and the mask (control bit 4) is 0. Setting the mask does not stop the status bit from being set.
- R10: The control register reads back the written bits 4:0, and the other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | PCM bit clock, synchronous to clk, slower than clk |
| fsync | input | 1 | Frame sync, marks the first bit of a frame |
| rxd | input | 4 | Serial receive lines 0..3 |
| addr | input | 2 | Register address: 0 control, 1 status, 2 cause |
| wr_en | input | 1 | Write strobe (control register only) |
| rd_en | input | 1 | Read strobe; causes the side effects of a read |
| wdata | input | 8 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Active-high level interrupt |

## Verification
The hardest situation to reach from the ports is a mismatch that arrives in `LOCKED_ST` after the status bit has already been cleared. If the status bit is still set, nothing visible distinguishes a lockout from a new capture. The stimulus therefore captures a mismatch and reads the status register to clear it, then sends a second mismatch at a different frame position. It expects status to stay 0 and the cause register to keep the first position. Only after the cause register has been read does a third mismatch set status again.

// File: rtl/pcm_cmp_pkg.sv
package pcm_cmp_pkg;
    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_STAT  = 2'd1;
    localparam logic [1:0] A_CAUSE = 2'd2;
    localparam logic [1:0] MODE_NO01 = 2'd2;

    typedef enum logic [0:0] {
        ARMED_ST  = 1'b0,
        LOCKED_ST = 1'b1
    } lock_state_t;
endpackage

// File: rtl/pcm_cmp_bitpos.sv
module pcm_cmp_bitpos #(
    parameter int SLOT_W = 5,
    localparam int POS_W = SLOT_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk,
    input  logic             fsync,
    output logic             smp,
    output logic [POS_W-1:0] cur_pos
);
    logic             bclk_q;
    logic [POS_W-1:0] pos_q;

    assign smp     = bclk & ~bclk_q;
    assign cur_pos = fsync ? '0 : pos_q + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
            pos_q  <= '1;
        end else begin
            bclk_q <= bclk;
            if (smp) pos_q <= cur_pos;
        end
    end
endmodule

// File: rtl/pcm_cmp_pairs.sv
module pcm_cmp_pairs #(
    parameter int LINES = 4,
    localparam int PAIRS = LINES / 2
) (
    input  logic             smp,
    input  logic [LINES-1:0] rxd,
    input  logic [PAIRS-1:0] en,
    input  logic [1:0]       pmode,
    output logic [PAIRS-1:0] mis
);
    import pcm_cmp_pkg::*;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        logic live;
        if (p == 0) begin : g_first
            assign live = en[p] && (pmode != MODE_NO01);
        end else begin : g_rest
            assign live = en[p];
        end
        assign mis[p] = smp && live && (rxd[2*p] != rxd[2*p+1]);
    end
endmodule

// File: rtl/pcm_cmp_irqfsm.sv
module pcm_cmp_irqfsm (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hit,
    input  logic                     rd_cause,
    output pcm_cmp_pkg::lock_state_t state,
    output logic                     capture
);
    import pcm_cmp_pkg::*;

    lock_state_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ARMED_ST;
        else        state <= nxt;
    end

    always_comb begin
        nxt     = state;
        capture = 1'b0;
        unique case (state)
            ARMED_ST: begin
                if (hit) begin
                    capture = 1'b1;
                    nxt     = LOCKED_ST;
                end
            end
            LOCKED_ST: begin
                if (rd_cause) nxt = ARMED_ST;
            end
        endcase
    end
endmodule

// File: rtl/pcm_redund_cmp.sv
module pcm_redund_cmp #(
    parameter int SLOT_W = 5,
    parameter int DW     = 16,
    localparam int LINES = 4,
    localparam int PAIRS = LINES / 2,
    localparam int POS_W = SLOT_W + 3,
    localparam int CW    = PAIRS + POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk,
    input  logic             fsync,
    input  logic [LINES-1:0] rxd,
    input  logic [1:0]       addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       wdata,
    output logic [DW-1:0]    rdata,
    output logic             irq
);
    import pcm_cmp_pkg::*;

    logic [PAIRS-1:0] en_q;
    logic [1:0]       pmode_q;
    logic             mask_q;
    logic             status_q;
    logic [CW-1:0]    cause_q;
    logic             smp, capture;
    logic [POS_W-1:0] cur_pos;
    logic [PAIRS-1:0] mis;
    lock_state_t      state;
    logic             rd_stat, rd_cause;

    assign rd_stat  = rd_en && (addr == A_STAT);
    assign rd_cause = rd_en && (addr == A_CAUSE);

    pcm_cmp_bitpos #(.SLOT_W(SLOT_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
        .smp(smp), .cur_pos(cur_pos)
    );

    pcm_cmp_pairs #(.LINES(LINES)) u_pairs (
        .smp(smp), .rxd(rxd), .en(en_q), .pmode(pmode_q), .mis(mis)
    );

    pcm_cmp_irqfsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hit(|mis), .rd_cause(rd_cause),
        .state(state), .capture(capture)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= '0;
            pmode_q  <= '0;
            mask_q   <= 1'b0;
            status_q <= 1'b0;
            cause_q  <= '0;
        end else begin
            if (wr_en && addr == A_CTRL) begin
                en_q    <= wdata[PAIRS-1:0];
                pmode_q <= wdata[3:2];
                mask_q  <= wdata[4];
            end
            if (capture) begin
                status_q <= 1'b1;
                cause_q  <= {cur_pos, mis};
            end else if (rd_stat) begin
                status_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL:  rdata[4:0]    = {mask_q, pmode_q, en_q};
            A_STAT:  rdata[0]      = status_q;
            A_CAUSE: rdata[CW-1:0] = cause_q;
            default: rdata         = '0;
        endcase
    end

    assign irq = status_q & ~mask_q;
endmodule

// File: rtl/pcm_redund_cmp_chk.sv
module pcm_redund_cmp_chk #(
    parameter int CW = 10
) (
    input logic                     clk,
    input logic                     rst_n,
    input pcm_cmp_pkg::lock_state_t state,
    input logic                     capture,
    input logic [1:0]               mis,
    input logic [1:0]               en_q,
    input logic [1:0]               pmode_q,
    input logic                     mask_q,
    input logic                     status_q,
    input logic [CW-1:0]            cause_q,
    input logic                     rd_stat,
    input logic                     rd_cause,
    input logic                     irq
);
    import pcm_cmp_pkg::*;

    // R2
    capture_sets_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> status_q);

    // R4
    off_pairs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == 2'b00) |-> (mis == 2'b00));

    // R5
    mode2_no01_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pmode_q == MODE_NO01) |-> !mis[0]);

    // R6
    stat_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !capture) |=> !status_q);

    // R7
    cause_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LOCKED_ST && !rd_cause) |=> $stable(cause_q));

    // R7
    locked_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LOCKED_ST) |-> !capture);

    // R9
    mask_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |-> !irq);
endmodule

bind pcm_redund_cmp pcm_redund_cmp_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .capture(capture), .mis(mis),
    .en_q(en_q), .pmode_q(pmode_q), .mask_q(mask_q), .status_q(status_q),
    .cause_q(cause_q), .rd_stat(rd_stat), .rd_cause(rd_cause), .irq(irq)
);

// File: tb/pcm_redund_cmp_tb.sv
module pcm_redund_cmp_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0, fsync = 1'b0;
    logic [3:0]  rxd = 4'h0;
    logic [1:0]  addr = 2'd0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wdata = 8'h0;
    logic [15:0] rdata;
    logic        irq;

    int vectors = 0, fails = 0;
    logic [15:0] expq[$];
    string       tagq[$];
    logic [7:0]  bpos = 8'hFF;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    pcm_redund_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .rxd(rxd),
        .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    // monitor: compares every read against the scoreboard queue
    always @(negedge clk) begin
        #2;
        if (rd_en) begin
            logic [15:0] e;
            string       t;
            e = expq.pop_front();
            t = tagq.pop_front();
            vectors++;
            if (rdata !== e) begin
                fails++;
                $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
            end
        end
    end

    task automatic rd(input logic [1:0] a, input logic [15:0] e, input string t);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        expq.push_back(e); tagq.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        addr = 2'd0; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input logic fs, input logic [3:0] d);
        @(negedge clk);
        bclk = 1'b0; fsync = fs; rxd = d;
        @(negedge clk);
        bclk = 1'b1;
        bpos = fs ? 8'd0 : bpos + 8'd1;
        @(negedge clk);
        @(negedge clk);
        bclk = 1'b0;
    endtask

    task automatic ticks(input int n, input logic [3:0] d);
        for (int i = 0; i < n; i++) tick(1'b0, d);
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        #2;
        vectors++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s: irq=%b expected=%b", t, irq, e);
        end
    endtask

    function automatic logic [15:0] cause(input logic [7:0] p, input logic f23, input logic f01);
        return {6'd0, p[7:3], p[2:0], f23, f01};
    endfunction

    initial begin
        logic [7:0] p1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, 16'h0, "R1 ctrl");
        rd(2'd1, 16'h0, "R1 status");
        rd(2'd2, 16'h0, "R1 cause");
        chk_irq(1'b0, "R1 irq");

        // R4 nothing enabled: mismatching data is ignored
        tick(1'b1, 4'b0101);
        ticks(3, 4'b1001);
        rd(2'd1, 16'h0, "R4 both off");

        // R10 readback, then enable pair 0/1
        wr(8'hE1);
        rd(2'd0, 16'h0001, "R10 ctrl readback");

        // R2 + R8: mismatch at slot 2 bit 5
        tick(1'b1, 4'b0000);
        ticks(20, 4'b0011);
        tick(1'b0, 4'b0001);
        p1 = bpos;
        chk_irq(1'b1, "R9 irq raised");
        rd(2'd1, 16'h1, "R2 status set");
        rd(2'd1, 16'h0, "R6 status cleared");
        chk_irq(1'b0, "R9 irq dropped");

        // R7 locked: new mismatch ignored, cause frozen
        ticks(4, 4'b0010);
        rd(2'd1, 16'h0, "R7 no new status");
        rd(2'd2, cause(p1, 1'b0, 1'b1), "R8 cause slot2 bit5");
        tick(1'b0, 4'b0010);
        rd(2'd1, 16'h1, "R7 rearmed status");
        rd(2'd2, cause(bpos, 1'b0, 1'b1), "R8 cause after rearm");
        rd(2'd1, 16'h0, "R6 clear again");

        // R3 only pair 2/3 enabled
        wr(8'h02);
        tick(1'b1, 4'b0001);
        rd(2'd1, 16'h0, "R4 pair01 off");
        tick(1'b0, 4'b0100);
        rd(2'd2, cause(bpos, 1'b1, 1'b0), "R3 cause pair23");
        rd(2'd1, 16'h1, "R3 status");

        // R8 both pairs differ on same bit
        wr(8'h03);
        tick(1'b1, 4'b0000);
        ticks(9, 4'b1111);
        tick(1'b0, 4'b1001);
        rd(2'd2, cause(bpos, 1'b1, 1'b1), "R8 both flags");
        rd(2'd1, 16'h1, "R8 status");

        // R5 mode 2 disables pair 0/1
        wr(8'h0B);
        rd(2'd0, 16'h000B, "R10 mode readback");
        tick(1'b1, 4'b0001);
        rd(2'd1, 16'h0, "R5 pair01 forced off");
        tick(1'b0, 4'b1000);
        rd(2'd1, 16'h1, "R5 pair23 still live");
        rd(2'd2, cause(bpos, 1'b1, 1'b0), "R5 cause");

        // R9 mask: status set, irq stays low
        wr(8'h11);
        tick(1'b1, 4'b0010);
        chk_irq(1'b0, "R9 masked");
        rd(2'd1, 16'h1, "R9 status despite mask");
        rd(2'd2, cause(8'd0, 1'b0, 1'b1), "R8 position zero at fsync");

        repeat (4) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: expired, expected completion");
            end
        join_any
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule